// File: doc/BRIEF.md
# Three-Wire Serial Programming Master

This block writes control words into radio-frequency devices such as synthesizers. The devices share one serial clock line and one serial data line. Each device also has its own active-low latch-enable line. A device that sees its enable high ignores the clock and data lines. This lets any number of devices sit on the same two wires.

A host offers a word and a device index through a valid/ready handshake. The master then does four things in turn:
- It pulls the selected enable low.
- It shifts the word out most significant bit first, one bit per rising clock edge.
- It holds the enable low for a short tail after the last clock edge, then raises it.
- It keeps every enable high for a long recovery gap before it will accept another word.

Every timing window is a minimum in nanoseconds. The block turns each one into a whole number of system-clock cycles from a clock-period parameter. The first three bits of a word form the address field. The target latches this field on the falling clock edge that follows the third rising edge. The master therefore always completes that falling edge while the enable is still low.

Top module: `tw3_prog_master`

## Requirements
- R1: After reset, every enable line is high, the serial clock is low and the master signals ready.
- R2: During a transfer, only the enable line whose index was given with the accepted word is low. All other enable lines stay high.
- R3: Each transfer produces exactly WORD_W rising clock edges. The data bits sampled at those edges reproduce the accepted word, most significant bit first.
- R4: The first rising clock edge comes at least 40 ns after the enable falls. The data line is stable for at least 20 ns before every rising edge and does not change while the clock is high.
- R5: Every clock high phase lasts at least 50 ns. Every low phase between two bits of one word also lasts at least 50 ns.
- R6: The enable stays low for at least 20 ns after the last falling clock edge. The clock is low when the enable rises.
- R7: Once an enable has risen, no enable falls again for at least 4000 ns. Ready is low from the accepting edge until that gap has ended.
- R8: A falling clock edge follows the third rising edge while the enable is still low. At that moment the three bits shifted in equal the top three bits of the word.
- R9: Words and device indices presented while the master is busy are ignored. The transfer in progress sends the word and device index that were accepted.
- R10: The serial clock stays low whenever every enable line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host offers a word |
| req_ready | output | 1 | Master can accept a word this cycle |
| req_word | input | WORD_W | Word to send; its top three bits are the address field |
| req_dev | input | DEV_W | Index of the target device |
| sclk | output | 1 | Shared serial clock, idles low |
| sdat | output | 1 | Shared serial data |
| sle_n | output | NUM_DEV | Active-low latch enable, one per device |

## Verification
Two events can land on the same cycle: the end of the recovery gap and the arrival of a new request. The bench provokes this by holding valid high with the next word queued behind the current transfer. The new word is then accepted on the very first ready cycle. A device model on the lines must then measure an enable-high gap of at least 4000 ns, and it must capture the second word intact. The same runs also change the word and device index on the host side during busy periods. The bench judges this by checking that only the accepted word reaches the target.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_TAIL = 3'd4,
    ST_GAP  = 3'd5
  } tw3_state_e;

  // Smallest cycle count whose span covers ns (at least one cycle).
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int width_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tw3_interval.sv
module tw3_interval #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tw3_shreg.sv
module tw3_shreg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb,
  output logic              last_bit
);
  localparam int BC_W = (WORD_W < 2) ? 1 : $clog2(WORD_W);

  logic [WORD_W-1:0] sr;
  logic [BC_W-1:0]   left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= load_word;
      left <= BC_W'(WORD_W - 1);
    end else if (shift) begin
      sr   <= sr << 1;
      left <= left - 1'b1;
    end
  end

  assign msb      = sr[WORD_W-1];
  assign last_bit = (left == '0);

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last_bit);
endmodule

// File: rtl/tw3_sel_decode.sv
module tw3_sel_decode #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic               enable,
  input  logic [DEV_W-1:0]   dev,
  output logic [NUM_DEV-1:0] le_n
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_line
    assign le_n[g] = !(enable && (dev == DEV_W'(g)));
  end
endmodule

// File: rtl/tw3_prog_master.sv
module tw3_prog_master
  import tw3_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int NUM_DEV   = 4,
  parameter int CLK_NS    = 10,
  parameter int T_LEAD_NS = 40,
  parameter int T_DSU_NS  = 20,
  parameter int T_HIGH_NS = 50,
  parameter int T_LOW_NS  = 50,
  parameter int T_TAIL_NS = 20,
  parameter int T_GAP_NS  = 4000,
  localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WORD_W-1:0]  req_word,
  input  logic [DEV_W-1:0]   req_dev,
  output logic               sclk,
  output logic               sdat,
  output logic [NUM_DEV-1:0] sle_n
);
  localparam int LEAD_C = max2(ns_to_cyc(T_LEAD_NS, CLK_NS), ns_to_cyc(T_DSU_NS, CLK_NS));
  localparam int LOW_C  = max2(ns_to_cyc(T_LOW_NS, CLK_NS), ns_to_cyc(T_DSU_NS, CLK_NS));
  localparam int HIGH_C = ns_to_cyc(T_HIGH_NS, CLK_NS);
  localparam int TAIL_C = ns_to_cyc(T_TAIL_NS, CLK_NS);
  localparam int GAP_C  = ns_to_cyc(T_GAP_NS, CLK_NS);
  localparam int CNT_W  = width_for(max2(max2(LEAD_C, GAP_C), max2(LOW_C, max2(HIGH_C, TAIL_C))));

  localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_C - 1);
  localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_C - 1);
  localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_C - 1);
  localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL_C - 1);
  localparam logic [CNT_W-1:0] GAP_V  = CNT_W'(GAP_C - 1);

  tw3_state_e       st;
  logic [DEV_W-1:0] dev_q;
  logic             sclk_q;

  // Named internal events
  logic accept_evt;
  logic tmr_done;
  logic last_bit;
  logic bit_msb;
  logic shift_evt;
  logic last_fall_evt;
  logic gap_done_evt;
  logic link_active;
  logic tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready     = (st == ST_IDLE);
  assign accept_evt    = req_valid && req_ready;
  assign link_active   = (st == ST_LEAD) || (st == ST_HIGH) || (st == ST_LOW) || (st == ST_TAIL);
  assign shift_evt     = (st == ST_HIGH) && tmr_done && !last_bit;
  assign last_fall_evt = (st == ST_HIGH) && tmr_done && last_bit;
  assign gap_done_evt  = (st == ST_GAP) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: if (accept_evt) begin tmr_load = 1'b1; tmr_val = LEAD_V; end
      ST_LEAD: if (tmr_done)   begin tmr_load = 1'b1; tmr_val = HIGH_V; end
      ST_HIGH: if (tmr_done)   begin tmr_load = 1'b1; tmr_val = last_bit ? TAIL_V : LOW_V; end
      ST_LOW:  if (tmr_done)   begin tmr_load = 1'b1; tmr_val = HIGH_V; end
      ST_TAIL: if (tmr_done)   begin tmr_load = 1'b1; tmr_val = GAP_V; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dev_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept_evt) begin
          dev_q <= req_dev;
          st    <= ST_LEAD;
        end
        ST_LEAD: if (tmr_done) begin
          sclk_q <= 1'b1;
          st     <= ST_HIGH;
        end
        ST_HIGH: if (tmr_done) begin
          sclk_q <= 1'b0;
          st     <= last_bit ? ST_TAIL : ST_LOW;
        end
        ST_LOW: if (tmr_done) begin
          sclk_q <= 1'b1;
          st     <= ST_HIGH;
        end
        ST_TAIL: if (tmr_done) st <= ST_GAP;
        ST_GAP:  if (tmr_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  tw3_interval #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  tw3_shreg #(.WORD_W(WORD_W)) shreg_i (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .load_word(req_word),
    .shift(shift_evt), .msb(bit_msb), .last_bit(last_bit)
  );

  tw3_sel_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) dec_i (
    .enable(link_active), .dev(dev_q), .le_n(sle_n)
  );

  assign sclk = sclk_q;
  assign sdat = bit_msb && link_active;

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sle_n));
  // R10
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&sle_n) |-> !sclk);
  // R7
  ready_idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&sle_n));
  // R4
  data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdat));
  // R6
  release_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&sle_n) |-> (!sclk && $past(!sclk)));
  // R7
  gap_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done_evt |=> req_ready);
endmodule

// File: tb/tw3_prog_master_tb.sv
module tw3_prog_master_tb_top;
  localparam int CLK_NS  = 10;
  localparam int WORD_W  = 24;
  localparam int NUM_DEV = 4;
  localparam int DEV_W   = 2;
  localparam int MAXT    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [WORD_W-1:0] req_word = '0;
  logic [DEV_W-1:0]  req_dev = '0;
  logic sclk, sdat;
  logic [NUM_DEV-1:0] sle_n;

  always #(CLK_NS/2) clk = ~clk;

  tw3_prog_master #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV), .CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_dev(req_dev), .sclk(sclk), .sdat(sdat), .sle_n(sle_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Minimum cycles so that n*CLK_NS covers the given nanoseconds.
  function automatic int min_cyc(input int ns);
    int n = 1;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction

  logic [WORD_W-1:0] exp_word [MAXT];
  int                exp_dev  [MAXT];
  int wr_idx = 0;
  int rd_idx = 0;

  // Target-side monitor
  int cyc = 0;
  logic [NUM_DEV-1:0] p_sle = '1;
  logic p_sclk = 1'b0, p_sdat = 1'b0;
  int t_le_fall = 0, t_le_rise = 0, t_sclk = 0, t_sdat = 0;
  int nbits = 0, nfalls = 0;
  bit seen_rise = 1'b0;
  logic [WORD_W-1:0] cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ((&sle_n) && (sclk != p_sclk)) chk(1'b0, "R10 clock toggled while idle", sclk, p_sclk);
      chk($countones(~sle_n) <= 1, "R2 lines low", $countones(~sle_n), 1);
      if (!(&sle_n)) chk(!req_ready, "R7 ready while busy", req_ready, 0);
      for (int d = 0; d < NUM_DEV; d++) begin
        if (p_sle[d] && !sle_n[d]) begin
          if (seen_rise) chk(cyc - t_le_rise >= min_cyc(4000), "R7 gap cycles", cyc - t_le_rise, min_cyc(4000));
          chk(d == exp_dev[rd_idx], "R2/R9 selected line", d, exp_dev[rd_idx]);
          t_le_fall = cyc; nbits = 0; nfalls = 0; cap = '0;
        end
      end
      if (!p_sclk && sclk) begin
        if (nbits == 0) chk(cyc - t_le_fall >= min_cyc(40), "R4 lead cycles", cyc - t_le_fall, min_cyc(40));
        else            chk(cyc - t_sclk >= min_cyc(50), "R5 low cycles", cyc - t_sclk, min_cyc(50));
        chk(cyc - t_sdat >= min_cyc(20), "R4 data setup cycles", cyc - t_sdat, min_cyc(20));
        cap = {cap[WORD_W-2:0], sdat};
        nbits++;
        t_sclk = cyc;
      end
      if (p_sclk && !sclk) begin
        chk(cyc - t_sclk >= min_cyc(50), "R5 high cycles", cyc - t_sclk, min_cyc(50));
        nfalls++;
        if (nfalls == 3) begin
          chk(!(&sle_n), "R8 enable low at address fall", sle_n, 0);
          chk(cap[2:0] == exp_word[rd_idx][WORD_W-1 -: 3], "R8 address field", cap[2:0], exp_word[rd_idx][WORD_W-1 -: 3]);
        end
        t_sclk = cyc;
      end
      if (sdat != p_sdat) begin
        chk(!sclk, "R4 data moved while clock high", sclk, 0);
        t_sdat = cyc;
      end
      for (int d = 0; d < NUM_DEV; d++) begin
        if (!p_sle[d] && sle_n[d]) begin
          chk(nbits == WORD_W, "R3 bit count", nbits, WORD_W);
          chk(cap == exp_word[rd_idx], "R3/R9 captured word", cap, exp_word[rd_idx]);
          chk(!sclk, "R6 clock low at release", sclk, 0);
          chk(cyc - t_sclk >= min_cyc(20), "R6 tail cycles", cyc - t_sclk, min_cyc(20));
          rd_idx++; t_le_rise = cyc; seen_rise = 1'b1;
        end
      end
    end
    p_sle = sle_n; p_sclk = sclk; p_sdat = sdat;
  end

  // Offer a word; on acceptance record it. If busy_noise, change inputs while busy.
  task automatic send(input logic [WORD_W-1:0] w, input int dev, input bit busy_noise, input bit keep_valid);
    req_word  = w;
    req_dev   = DEV_W'(dev);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_word[wr_idx] = w;
    exp_dev[wr_idx]  = dev;
    wr_idx++;
    @(negedge clk);
    if (busy_noise) begin
      for (int i = 0; i < 60; i++) begin
        req_word = WORD_W'($urandom);
        req_dev  = DEV_W'($urandom);
        @(negedge clk);
      end
    end
    if (!keep_valid) req_valid = 1'b0;
  endtask

  bit finished = 1'b0;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", cyc, 150000);
      summary();
    end
  end

  initial begin
    process::self().srandom(32'd1207);
    repeat (3) @(negedge clk);
    // R1
    chk(sle_n == '1, "R1 enables after reset", sle_n, 4'hF);
    chk(sclk == 1'b0, "R1 clock after reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    // directed corners
    send(24'hFFFFFF, 0, 1'b0, 1'b0);
    send(24'h000000, 3, 1'b0, 1'b0);
    send(24'hA5A5A5, 1, 1'b1, 1'b0);
    // back-to-back: new word meets end of gap (R7)
    send(24'h5A5A5A, 2, 1'b0, 1'b1);
    send(24'hC00001, 2, 1'b0, 1'b1);
    send(24'h3FFFFE, 0, 1'b1, 1'b0);
    // random traffic
    for (int k = 0; k < 18; k++) begin
      send(WORD_W'($urandom), int'($urandom % NUM_DEV), ($urandom % 3) == 0, ($urandom % 2) == 0);
      repeat ($urandom % 6) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!(req_ready && rd_idx == wr_idx)) @(negedge clk);
    chk(rd_idx == wr_idx, "R3 transfers seen", rd_idx, wr_idx);
    chk(sle_n == '1 && !sclk, "R10 quiet after traffic", {sle_n, sclk}, 5'h1E);
    finished = 1'b1;
    summary();
  end
endmodule